// File: doc/BRIEF.md
# Three-Wire Serial Word Memory Slave

This block is the slave side of a three-wire serial memory port. A host selects it with a select line, clocks it with a serial clock and feeds commands on a serial data input. The block holds a 64-word by 16-bit register array. It answers on a serial data output that has its own enable, so that a pad can leave the line undriven whenever no read data is due.

A command opens with a start bit, which is the first 1 seen after selection. Any zeros before it are skipped. Two opcode bits and six address bits follow. A read streams the addressed word out MSB first, after a single zero dummy bit. It moves on to the next word, wrapping at the top of the array, for as long as the host keeps clocking with the select held. A write carries 16 data bits after the address. Writes take effect only after an enable command has opened the write-enable latch, which reset closes. Dropping the select line at any point abandons the command in progress.

The serial inputs are sampled in the system clock domain. They are assumed to be already synchronous to it, and the serial clock must stay high and low for at least one system clock each.

Top module: `mw_slave`

## Requirements
- R1: After select rises, zeros on the data input clocked before the first 1 are skipped; that first 1 is the start bit and decoding begins after it.
- R2: A read is start bit, opcode 1,0, then address bits from bit 5 down to bit 0; the word is shifted out most significant bit first, one bit per serial clock rising edge.
- R3: On the serial clock rising edge that samples address bit 0 of a read, the output enable turns on and the output drives a single 0 before bit 15.
- R4: While select stays high and the serial clock keeps running after bit 0, the next address is read with no new command; its bit 15 directly follows bit 0 of the previous word, and address 63 is followed by address 0.
- R5: The output enable is low after reset, after select falls, and during all non-read commands.
- R6: Reset clears the write-enable latch and all words of the array to zero.
- R7: Opcode 0,0 with address bits 5:4 equal to 1,1 sets the write-enable latch; opcode 0,0 with address bits 5:4 equal to 0,0 clears it; bits 3:0 are don't-care and the latch keeps its state between commands.
- R8: A write is start bit, opcode 0,1, six address bits and 16 data bits MSB first; the word is stored after bit 0 only when the latch is set, and otherwise the array is left unchanged.
- R9: Select falling aborts any command: output enable goes low, a partly received write stores nothing, and the next selection waits for a new start bit.
- R10: Reads return the same data whether the write-enable latch is set or clear.
- R11: Serial clocks after the last data bit of a write, with select still high, have no effect; in particular they do not write the next address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock; its rising edges shift bits in and out |
| sdin | input | 1 | Serial command, address and write data |
| sdout | output | 1 | Serial read data |
| sdout_en | output | 1 | Drive enable for sdout; low means high impedance |

## Verification
The hardest state to reach is the word boundary inside an auto-incrementing read: bit 0 of one word must be followed, with no gap, by bit 15 of the next, including the step from address 63 to 0. The stimulus writes distinct patterns near the top and bottom of the array, then starts a read at address 62 and clocks four words without deselecting. A queue of expected bits, filled from a model of the array, is compared bit by bit against the output. Aborts are reached by dropping select partway through a read and partway through a write, and then reading back the untouched word.

// File: rtl/mw_pkg.sv
// Package mw_pkg
// Shared decoder state type and opcode values for the serial memory slave.
// Assumes a two-bit opcode field.
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start bit
        ST_OPC,    // receiving opcode
        ST_ADDR,   // receiving address
        ST_WDATA,  // receiving write data
        ST_READ,   // streaming read data
        ST_HOLD    // command finished, ignore clocks until deselect
    } mw_state_e;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_CTRL  = 2'b00;

    localparam logic [1:0] CTRL_EN   = 2'b11;
    localparam logic [1:0] CTRL_DIS  = 2'b00;

endpackage

// File: rtl/mw_sk_edge.sv
// Module mw_sk_edge
// Turns the serial clock level into a one-cycle strobe at each rising edge
// while the slave is selected. Assumes sclk is synchronous to clk.
module mw_sk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sclk,
    output logic rise
);

    logic sclk_q;

    // Remember last serial clock level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk;
        end
    end

    // Rising edge qualified by select
    always_comb begin
        rise = sel & sclk & ~sclk_q;
    end

endmodule

// File: rtl/mw_wen_latch.sv
// Module mw_wen_latch
// Write-enable latch. Closed by reset, opened by a set pulse, closed by a
// clear pulse. Assumes set and clear never arrive in the same cycle; if they
// do, clear wins.
module mw_wen_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_p,
    input  logic clr_p,
    output logic wen
);

    // Hold the enable state between commands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen <= 1'b0;
        end else if (clr_p) begin
            wen <= 1'b0;
        end else if (set_p) begin
            wen <= 1'b1;
        end
    end

endmodule

// File: rtl/mw_array.sv
// Module mw_array
// Word storage: asynchronous read port, synchronous write port, cleared on
// reset. Assumes WORDS is a power of two matching ADDR_W.
module mw_array #(
    parameter int WORDS  = 64,
    parameter int DATA_W = 16,
    localparam int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [WORDS];

    // Clear on reset, store on write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read the addressed word
    always_comb begin
        rdata = mem[raddr];
    end

endmodule

// File: rtl/mw_decoder.sv
// Module mw_decoder
// Command state machine: start-bit search, opcode and address shifting,
// write data capture, read streaming with auto-increment, output enable.
// Assumes one rise strobe per serial clock rising edge.
module mw_decoder
    import mw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rise,
    input  logic              sdin,
    input  logic              wen,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr,
    output logic              sdout,
    output logic              sdout_en,
    output logic              mem_we,
    output logic [DATA_W-1:0] wdata,
    output logic              wen_set,
    output logic              wen_clr
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_OPC  = CNT_W'(1);
    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);

    mw_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        opc;
    logic [DATA_W-1:0] shreg;
    logic [ADDR_W-1:0] addr_next;
    logic [DATA_W-1:0] word_cur;

    // Address with the current input bit shifted in
    always_comb begin
        addr_next = {addr[ADDR_W-2:0], sdin};
    end

    // Fresh word at the start of each read word, else remaining bits
    always_comb begin
        word_cur = (cnt == '0) ? rdata : shreg;
    end

    // Main command sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            opc      <= '0;
            addr     <= '0;
            shreg    <= '0;
            sdout    <= 1'b0;
            sdout_en <= 1'b0;
            mem_we   <= 1'b0;
            wdata    <= '0;
            wen_set  <= 1'b0;
            wen_clr  <= 1'b0;
        end else begin
            mem_we  <= 1'b0;
            wen_set <= 1'b0;
            wen_clr <= 1'b0;
            if (!sel) begin
                state    <= ST_IDLE;
                cnt      <= '0;
                sdout    <= 1'b0;
                sdout_en <= 1'b0;
            end else if (rise) begin
                case (state)
                    ST_IDLE: begin
                        if (sdin) begin
                            state <= ST_OPC;
                            cnt   <= '0;
                        end
                    end
                    ST_OPC: begin
                        opc <= {opc[0], sdin};
                        if (cnt == LAST_OPC) begin
                            state <= ST_ADDR;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_ADDR: begin
                        addr <= addr_next;
                        if (cnt == LAST_ADDR) begin
                            cnt <= '0;
                            case (opc)
                                OPC_READ: begin
                                    state    <= ST_READ;
                                    sdout    <= 1'b0;
                                    sdout_en <= 1'b1;
                                end
                                OPC_WRITE: begin
                                    state <= ST_WDATA;
                                end
                                OPC_CTRL: begin
                                    state <= ST_HOLD;
                                    if (addr_next[ADDR_W-1 -: 2] == CTRL_EN) begin
                                        wen_set <= 1'b1;
                                    end else if (addr_next[ADDR_W-1 -: 2] == CTRL_DIS) begin
                                        wen_clr <= 1'b1;
                                    end
                                end
                                default: begin
                                    state <= ST_HOLD;
                                end
                            endcase
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_WDATA: begin
                        shreg <= {shreg[DATA_W-2:0], sdin};
                        if (cnt == LAST_DATA) begin
                            wdata  <= {shreg[DATA_W-2:0], sdin};
                            mem_we <= wen;
                            state  <= ST_HOLD;
                            cnt    <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_READ: begin
                        sdout <= word_cur[DATA_W-1];
                        shreg <= {word_cur[DATA_W-2:0], 1'b0};
                        if (cnt == LAST_DATA) begin
                            cnt  <= '0;
                            addr <= addr + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        state <= ST_HOLD;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/mw_slave.sv
// Module mw_slave
// Top of the three-wire serial word memory slave. Connects the serial clock
// edge detector, command decoder, write-enable latch and word array.
// Assumes sel, sclk and sdin are synchronous to clk.
module mw_slave #(
    parameter int WORDS  = 64,
    parameter int DATA_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sclk,
    input  logic sdin,
    output logic sdout,
    output logic sdout_en
);

    localparam int ADDR_W = $clog2(WORDS);

    logic              rise;
    logic              wen_q;
    logic              wen_set;
    logic              wen_clr;
    logic              mem_we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;

    mw_sk_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .sclk  (sclk),
        .rise  (rise)
    );

    mw_decoder #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .rise     (rise),
        .sdin     (sdin),
        .wen      (wen_q),
        .rdata    (rdata),
        .addr     (addr),
        .sdout    (sdout),
        .sdout_en (sdout_en),
        .mem_we   (mem_we),
        .wdata    (wdata),
        .wen_set  (wen_set),
        .wen_clr  (wen_clr)
    );

    mw_wen_latch u_wen (
        .clk   (clk),
        .rst_n (rst_n),
        .set_p (wen_set),
        .clr_p (wen_clr),
        .wen   (wen_q)
    );

    mw_array #(
        .WORDS  (WORDS),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (addr),
        .wdata (wdata),
        .raddr (addr),
        .rdata (rdata)
    );

endmodule

// File: rtl/mw_slave_chk.sv
// Module mw_slave_chk
// Protocol checks for mw_slave, attached by bind.
module mw_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic sel,
    input logic sdout,
    input logic sdout_en,
    input logic wen_q,
    input logic mem_we
);

    // Deselect turns the output driver off on the next cycle
    assert_deselect_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !sdout_en);

    // Output turns on with the dummy zero
    assert_dummy_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdout_en) |-> (sdout == 1'b0));

    // Reset leaves writes disabled
    assert_reset_closed_R6: assert property (@(posedge clk)
        !rst_n |=> !wen_q);

    // The latch opens only as a result of a selected command
    assert_open_when_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wen_q) |-> $past(sel));

    // No store while writes are disabled
    assert_store_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wen_q);

endmodule

bind mw_slave mw_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .sdout    (sdout),
    .sdout_en (sdout_en),
    .wen_q    (wen_q),
    .mem_we   (mem_we)
);

// File: tb/mw_slave_bench.sv
module mw_slave_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_r = 1'b0;
    logic sk_r = 1'b0;
    logic di_r = 1'b0;
    logic sdout;
    logic sdout_en;

    int checks = 0;
    int fails = 0;
    string cur_tag = "R2";

    logic [15:0] model [64];
    logic        wen_m;
    logic        exp_q [$];
    event        ev_sample;

    always #10 clk = ~clk;

    mw_slave u_mw_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel_r),
        .sclk     (sk_r),
        .sdin     (di_r),
        .sdout    (sdout),
        .sdout_en (sdout_en)
    );

    task automatic check(input logic ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Monitor: compare each sampled output bit with the next expected one
    always @(ev_sample) begin
        logic eb;
        if (exp_q.size() == 0) begin
            check(1'b0, cur_tag, int'({sdout_en, sdout}), -1);
        end else begin
            eb = exp_q.pop_front();
            check(sdout_en === 1'b1 && sdout === eb, cur_tag,
                  int'({sdout_en, sdout}), int'({1'b1, eb}));
        end
    end

    task automatic sk_bit(input logic b, input logic smp);
        di_r = b;
        sk_r = 1'b1;
        @(negedge clk);
        if (smp) -> ev_sample;
        #1;
        sk_r = 1'b0;
        @(negedge clk);
    endtask

    task automatic sel_off();
        sel_r = 1'b0;
        sk_r  = 1'b0;
        di_r  = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [5:0] a, input int zeros,
                            input logic smp_last);
        sel_r = 1'b1;
        @(negedge clk);
        repeat (zeros) sk_bit(1'b0, 1'b0);
        sk_bit(1'b1, 1'b0);
        sk_bit(op[1], 1'b0);
        sk_bit(op[0], 1'b0);
        for (int i = 5; i >= 0; i--) sk_bit(a[i], (i == 0) && smp_last);
    endtask

    task automatic read_words(input logic [5:0] a, input int n, input int zeros, input string tag);
        cur_tag = tag;
        exp_q.push_back(1'b0);
        for (int w = 0; w < n; w++) begin
            logic [15:0] wd;
            wd = model[(int'(a) + w) % 64];
            for (int b = 15; b >= 0; b--) exp_q.push_back(wd[b]);
        end
        send_hdr(2'b10, a, zeros, 1'b1);
        repeat (16 * n) sk_bit(1'b0, 1'b1);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        sel_off();
        check(sdout_en == 1'b0, "R5", int'(sdout_en), 0);
    endtask

    task automatic write_word(input logic [5:0] a, input logic [15:0] d, input int extra);
        send_hdr(2'b01, a, 0, 1'b0);
        for (int b = 15; b >= 0; b--) sk_bit(d[b], 1'b0);
        check(sdout_en == 1'b0, "R5", int'(sdout_en), 0);
        repeat (extra) sk_bit(1'b1, 1'b0);
        sel_off();
        if (wen_m) model[a] = d;
    endtask

    task automatic ctrl(input logic en);
        send_hdr(2'b00, en ? 6'b110101 : 6'b001010, 0, 1'b0);
        check(sdout_en == 1'b0, "R5", int'(sdout_en), 0);
        sel_off();
        wen_m = en;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = 16'h0000;
        wen_m = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sdout_en == 1'b0, "R5", int'(sdout_en), 0);
        check(sdout == 1'b0, "R6", int'(sdout), 0);

        // R6: writes disabled after reset, array cleared
        write_word(6'd5, 16'h1234, 0);
        read_words(6'd5, 1, 0, "R6");

        // R7: enable, then R8 writes
        ctrl(1'b1);
        write_word(6'd0, 16'hA5C3, 0);
        write_word(6'd1, 16'h0F0F, 0);
        write_word(6'd2, 16'h8001, 0);
        write_word(6'd62, 16'hFFFE, 0);
        write_word(6'd63, 16'h7FFF, 0);
        read_words(6'd0, 1, 0, "R2");
        read_words(6'd0, 3, 0, "R4");
        // R4: wrap from 63 to 0
        read_words(6'd62, 4, 0, "R4");
        // R1: leading zeros before start
        read_words(6'd2, 1, 5, "R1");
        read_words(6'd1, 1, 1, "R1");

        // R11: trailing clocks after a write do nothing
        write_word(6'd10, 16'h3C3C, 20);
        read_words(6'd10, 2, 0, "R11");

        // R7/R8: disable, write ignored; R10 reads still work
        ctrl(1'b0);
        write_word(6'd1, 16'hDEAD, 0);
        read_words(6'd0, 3, 0, "R10");

        // R9: abort a read partway
        cur_tag = "R9";
        exp_q.push_back(1'b0);
        for (int b = 15; b >= 11; b--) exp_q.push_back(model[1][b]);
        send_hdr(2'b10, 6'd1, 0, 1'b1);
        repeat (5) sk_bit(1'b0, 1'b1);
        sel_r = 1'b0;
        @(negedge clk);
        check(sdout_en == 1'b0, "R9", int'(sdout_en), 0);
        check(exp_q.size() == 0, "R9", exp_q.size(), 0);
        sel_off();
        read_words(6'd1, 1, 0, "R9");

        // R9: abort a write partway, enabled
        ctrl(1'b1);
        send_hdr(2'b01, 6'd3, 0, 1'b0);
        repeat (8) sk_bit(1'b1, 1'b0);
        sel_off();
        read_words(6'd3, 1, 0, "R9");
        write_word(6'd3, 16'h5A5A, 0);
        read_words(6'd2, 2, 0, "R8");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule